// File: doc/BRIEF.md
# Branch Condition and Block Repeat Sequencer

This block belongs to the control path of an 8-bit accumulator CPU. For each machine cycle it answers two questions. The first is whether the instruction should advance to its next machine cycle (`next_m`). The second is whether the sequencer should return to opcode fetch (`set_m1`). A per-cycle selector code from the microcode picks the rule that applies. The rules cover a fixed advance or fetch, conditional branches, decrement-and-branch loops, repeating block transfers, and the extra cycles that a vectored interrupt needs.

Two pieces of state sit inside the block. The first is a condition bit. It is evaluated from the flags and a 3-bit condition code whenever the microcode asks for it. A short mode restricts the evaluation to the zero and carry tests, which the third clock of the opcode fetch uses. The second is a repeat-termination bit. It is loaded from the "count register equals one" status. Both bits are registered and clear on a synchronous active-high reset. The two decision outputs are formed combinationally from the selector, the live inputs and these two registers.

Top module: `cycle_restart_ctl`

## Requirements
- R1: With `eval_cond`=1 and `cond_short`=0, the condition bit seen from the next cycle on is decoded from `cc_code` over `flags` (bit0 zero, bit1 carry, bit2 parity, bit3 sign). The codes 0..7 test, in turn: zero clear, zero set, carry clear, carry set, parity clear, parity set, sign clear, sign set.
- R2: With `eval_cond`=1 and `cond_short`=1, only `cc_code[1:0]` is used, as code {0,cc_code[1:0]}. `cc_code[2]` has no effect in this mode.
- R3: The condition bit is 0 after reset and keeps its value in every cycle where `eval_cond`=0.
- R4: With `sel`=4 (conditional), `next_m` and `set_m1` both equal the inverse of the condition bit.
- R5: With `sel`=3 (short conditional), `set_m1` is the inverse of the condition bit and `next_m` is 0.
- R6: With `sel`=5 (decrement-and-branch), `set_m1` equals `flags[0]` and `next_m` is 0.
- R7: The repeat-termination bit is 0 after reset. It takes `count_is_one` at each clock edge where `rep_we`=1 and holds otherwise. A decision made in the same cycle as a load uses the old value.
- R8: With `sel`=6 (block repeat), `set_m1` = `non_rep` OR repeat-termination bit, and `next_m` is 0.
- R9: With `sel`=7 (block repeat with zero stop), `set_m1` = `non_rep` OR repeat-termination bit OR `flags[0]`, and `next_m` is 0.
- R10: With `sel`=8 (interrupt), `set_m1` = NOT(`in_intr` AND `im2`), and `next_m` is 0.
- R11: With `sel`=0, or with any code from 9 to 15, both outputs are 0. With `sel`=1 only `next_m` is 1. With `sel`=2 only `set_m1` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 4 | Sequencing rule selector |
| eval_cond | input | 1 | Evaluate and store the branch condition |
| cond_short | input | 1 | Restrict evaluation to the four short codes |
| cc_code | input | 3 | Condition code taken from the opcode |
| flags | input | 4 | {sign, parity, carry, zero} |
| non_rep | input | 1 | Block instruction is the non-repeating form |
| rep_we | input | 1 | Load the repeat-termination bit |
| count_is_one | input | 1 | 16-bit count register currently equals one |
| in_intr | input | 1 | Interrupt acknowledge in progress |
| im2 | input | 1 | Vectored interrupt mode active |
| next_m | output | 1 | Advance to the next machine cycle |
| set_m1 | output | 1 | Return to opcode fetch |

## Verification
Two functions can meet in one cycle. A block-repeat decision (`sel`=6 or 7) can coincide with a load of the repeat-termination bit, and a conditional decision (`sel`=4) can coincide with a fresh condition evaluation. The bench provokes the first case: it drives `rep_we` together with `sel`=6 while `count_is_one` differs from the stored bit. It judges `set_m1` against the old value in that cycle and against the new value in the next cycle. It provokes the second case the same way: it evaluates a condition whose result is the opposite of the stored one under `sel`=4, and expects the outputs to follow the stored bit until the following cycle.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int SEL_W  = 4;
  localparam int CODE_W = 3;
  localparam int FLAG_W = 4;
  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FP = 2;
  localparam int FS = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_IDLE  = 4'd0,
    SEL_ADV   = 4'd1,
    SEL_FETCH = 4'd2,
    SEL_SHORT = 4'd3,
    SEL_COND  = 4'd4,
    SEL_DJZ   = 4'd5,
    SEL_BLK   = 4'd6,
    SEL_BLKZ  = 4'd7,
    SEL_INTR  = 4'd8
  } sel_e;

  // code[2:1] picks the flag, code[0] picks its polarity
  function automatic logic cond_decode(input logic [CODE_W-1:0] code,
                                       input logic [FLAG_W-1:0] fl);
    logic pick;
    case (code[2:1])
      2'd0:    pick = fl[FZ];
      2'd1:    pick = fl[FC];
      2'd2:    pick = fl[FP];
      default: pick = fl[FS];
    endcase
    return pick ~^ code[0];
  endfunction
endpackage

// File: rtl/crs_cond_eval.sv
module crs_cond_eval
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_en,
  input  logic              short_en,
  input  logic [CODE_W-1:0] code,
  input  logic [FLAG_W-1:0] fl,
  output logic              cond_q
);
  logic [CODE_W-1:0] eff_code;

  always_comb begin
    eff_code = code;
    if (short_en) eff_code[CODE_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          cond_q <= 1'b0;
    else if (eval_en) cond_q <= cond_decode(eff_code, fl);
  end
endmodule

// File: rtl/crs_rep_latch.sv
module crs_rep_latch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= d;
  end
endmodule

// File: rtl/crs_decide.sv
module crs_decide
  import crs_pkg::*;
(
  input  sel_e sel,
  input  logic cond,
  input  logic zf,
  input  logic non_rep,
  input  logic rep_last,
  input  logic in_intr,
  input  logic im2,
  output logic next_m,
  output logic set_m1
);
  always_comb begin
    next_m = 1'b0;
    set_m1 = 1'b0;
    case (sel)
      SEL_ADV:   next_m = 1'b1;
      SEL_FETCH: set_m1 = 1'b1;
      SEL_SHORT: set_m1 = ~cond;
      SEL_COND: begin
        next_m = ~cond;
        set_m1 = ~cond;
      end
      SEL_DJZ:   set_m1 = zf;
      SEL_BLK:   set_m1 = non_rep | rep_last;
      SEL_BLKZ:  set_m1 = non_rep | rep_last | zf;
      SEL_INTR:  set_m1 = ~(in_intr & im2);
      default: ;
    endcase
  end
endmodule

// File: rtl/cycle_restart_ctl.sv
module cycle_restart_ctl
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic              eval_cond,
  input  logic              cond_short,
  input  logic [CODE_W-1:0] cc_code,
  input  logic [FLAG_W-1:0] flags,
  input  logic              non_rep,
  input  logic              rep_we,
  input  logic              count_is_one,
  input  logic              in_intr,
  input  logic              im2,
  output logic              next_m,
  output logic              set_m1
);
  logic cond_q;
  logic rep_last;

  crs_cond_eval u_cond (
    .clk(clk), .rst(rst), .eval_en(eval_cond), .short_en(cond_short),
    .code(cc_code), .fl(flags), .cond_q(cond_q)
  );

  crs_rep_latch #(.RST_VAL(1'b0)) u_rep (
    .clk(clk), .rst(rst), .we(rep_we), .d(count_is_one), .q(rep_last)
  );

  crs_decide u_dec (
    .sel(sel_e'(sel)), .cond(cond_q), .zf(flags[FZ]), .non_rep(non_rep),
    .rep_last(rep_last), .in_intr(in_intr), .im2(im2),
    .next_m(next_m), .set_m1(set_m1)
  );
endmodule

// File: rtl/cycle_restart_ctl_chk.sv
module cycle_restart_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] sel,
  input logic       eval_cond,
  input logic       rep_we,
  input logic       count_is_one,
  input logic [3:0] flags,
  input logic       in_intr,
  input logic       im2,
  input logic       cond_q,
  input logic       rep_last,
  input logic       next_m,
  input logic       set_m1
);
  p_cond_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !eval_cond |=> $stable(cond_q));
  p_cc_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'd4) |-> (next_m == set_m1) && (set_m1 == !cond_q));
  p_djz_r6: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'd5) |-> (set_m1 == flags[0]) && !next_m);
  p_rep_load_r7: assert property (@(posedge clk) disable iff (rst)
    rep_we |=> (rep_last == $past(count_is_one)));
  p_rep_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rep_we |=> $stable(rep_last));
  p_intr_r10: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'd8) |-> (set_m1 == !(in_intr && im2)) && !next_m);
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'd0 || sel > 4'd8) |-> !next_m && !set_m1);
endmodule

bind cycle_restart_ctl cycle_restart_ctl_chk chk_i (.*);

// File: tb/cycle_restart_ctl_tb_top.sv
module cycle_restart_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] sel;
  logic       eval_cond, cond_short, non_rep, rep_we, count_is_one, in_intr, im2;
  logic [2:0] cc_code;
  logic [3:0] flags;
  logic       next_m, set_m1;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cycle_restart_ctl dut_i (
    .clk(clk), .rst(rst), .sel(sel), .eval_cond(eval_cond), .cond_short(cond_short),
    .cc_code(cc_code), .flags(flags), .non_rep(non_rep), .rep_we(rep_we),
    .count_is_one(count_is_one), .in_intr(in_intr), .im2(im2),
    .next_m(next_m), .set_m1(set_m1)
  );

  function automatic bit exp_cond(input int code, input logic [3:0] f);
    case (code)
      0: return !f[0];
      1: return f[0];
      2: return !f[1];
      3: return f[1];
      4: return !f[2];
      5: return f[2];
      6: return !f[3];
      default: return f[3];
    endcase
  endfunction

  task automatic chk(input string req, input logic nm, input logic sm,
                     input bit enm, input bit esm);
    n_chk++;
    if (nm !== enm || sm !== esm) begin
      n_bad++;
      $display("FAIL %s: next_m/set_m1 = %b%b, expected %b%b", req, nm, sm, enm, esm);
    end
  endtask

  task automatic idle_inputs();
    sel = 4'd0; eval_cond = 0; cond_short = 0; cc_code = 0; flags = 0;
    non_rep = 0; rep_we = 0; count_is_one = 0; in_intr = 0; im2 = 0;
  endtask

  initial begin
    rst = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 chk("R11 reset idle", next_m, set_m1, 0, 0);
    sel = 4'd4; #0.5 chk("R3 reset cond", next_m, set_m1, 1, 1);
    sel = 4'd6; #0.5 chk("R7 reset rep", next_m, set_m1, 0, 0);

    // condition sweep, full and short
    for (int sh = 0; sh < 2; sh++)
      for (int code = 0; code < 8; code++)
        for (int f = 0; f < 16; f++) begin
          bit c;
          c = exp_cond(sh ? (code % 4) : code, f[3:0]);
          @(negedge clk);
          sel = 4'd0; eval_cond = 1; cond_short = sh[0]; cc_code = code[2:0]; flags = f[3:0];
          @(negedge clk);
          eval_cond = 0; cc_code = ~code[2:0]; flags = ~f[3:0]; sel = 4'd4;
          #1 chk(sh ? "R2 short CC" : "R1 full CC", next_m, set_m1, !c, !c);
          sel = 4'd3;
          #0.5 chk("R5 SS", next_m, set_m1, 0, !c);
        end

    // R3 hold across cycles, and evaluation coinciding with a CC decision
    @(negedge clk); eval_cond = 1; cond_short = 0; cc_code = 3'd1; flags = 4'b0001; sel = 4'd0;
    @(negedge clk); eval_cond = 0; flags = 4'b0000;
    repeat (3) @(negedge clk);
    #1 sel = 4'd4; #0.5 chk("R3 hold", next_m, set_m1, 0, 0);
    @(negedge clk); eval_cond = 1; cc_code = 3'd1; flags = 4'b0000; sel = 4'd4;
    #1 chk("R4 same-cycle old cond", next_m, set_m1, 0, 0);
    @(negedge clk); eval_cond = 0;
    #1 chk("R4 new cond", next_m, set_m1, 1, 1);

    // R6
    for (int z = 0; z < 2; z++) begin
      @(negedge clk); idle_inputs(); sel = 4'd5; flags = {3'b111, z[0]};
      #1 chk("R6 djz", next_m, set_m1, 0, z[0]);
    end

    // R7/R8/R9 repeat termination
    for (int ci = 0; ci < 2; ci++)
      for (int nr = 0; nr < 2; nr++)
        for (int z = 0; z < 2; z++) begin
          @(negedge clk); idle_inputs(); rep_we = 1; count_is_one = ci[0];
          @(negedge clk); rep_we = 0; count_is_one = !ci[0]; non_rep = nr[0];
          flags = {3'b000, z[0]}; sel = 4'd6;
          #1 chk("R8 block", next_m, set_m1, 0, nr[0] | ci[0]);
          sel = 4'd7;
          #0.5 chk("R9 block zero", next_m, set_m1, 0, nr[0] | ci[0] | z[0]);
        end

    // R7 load coinciding with a block decision
    @(negedge clk); idle_inputs(); rep_we = 1; count_is_one = 1;
    @(negedge clk); rep_we = 1; count_is_one = 0; sel = 4'd6;
    #1 chk("R7 same-cycle old rep", next_m, set_m1, 0, 1);
    @(negedge clk); rep_we = 0; count_is_one = 1;
    #1 chk("R7 new rep", next_m, set_m1, 0, 0);
    repeat (2) @(negedge clk);
    #1 chk("R7 hold", next_m, set_m1, 0, 0);

    // R10
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle_inputs(); sel = 4'd8; in_intr = k[0]; im2 = k[1];
      #1 chk("R10 intr", next_m, set_m1, 0, !(k[0] & k[1]));
    end

    // R11 fixed and unused codes, with other inputs active
    for (int s = 0; s < 16; s++) begin
      if (s >= 3 && s <= 8) continue;
      @(negedge clk); idle_inputs(); flags = 4'hF; non_rep = 1; sel = s[3:0];
      #1 chk("R11 fixed", next_m, set_m1, s == 1, s == 2);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule